// File: doc/BRIEF.md
# Emulation Memory Mapper

This block sits between an emulated processor's bus and two kinds of memory: internal emulation RAM made of relocatable 8 KB blocks, and the memory of the target board. For each bus cycle it takes the address and direction and decides where the cycle goes. A fine map at 256-byte granularity can send a region out to the target, and that map always wins over the coarse block map. Internal accesses select one emulation block. If no block is placed at the address, nothing is selected and the bus floats. Any block can be write-protected so that it behaves like ROM.

A host loads the tables through a small register port. An index register chooses the entry, and a data write updates that entry. The decision for a cycle is taken once, at the start strobe, by a five-state machine with these states: `ST_IDLE`, `ST_EXT`, `ST_SIM`, `ST_SIM_WP` and `ST_FLOAT`. From `ST_IDLE`, a strobe moves the machine to `ST_EXT` when the region is external. Otherwise it moves to `ST_SIM_WP` for a write to a protected block, to `ST_SIM` for any other access that hits a block, and to `ST_FLOAT` when no block hits. From each of the other four states, `bus_done` returns the machine to `ST_IDLE`. A sticky violation flag records suppressed writes until the host clears it.

Top module: `emu_mem_mapper`

## Requirements
- R1: After reset, every 256-byte region is internal, block i sits at 8 KB page i (page = addr[15:13]), no block is protected, the violation flag is 0, and `blk_sel`, `tgt_en`, `tgt_rd` and `wr_inhibit` are all 0.
- R2: The routing outputs follow the table contents present on the clock edge at which `bus_strobe` is sampled in idle. They hold until `bus_done` is sampled. On the edge after that they return to 0.
- R3: If the region bit for addr[15:8] is 1 (external), then `tgt_en`=1 and `blk_sel`=0, whatever the block placement.
- R4: For an internal region, `blk_sel` is one-hot on the block whose page equals addr[15:13].
- R5: For an internal region that no block covers, `blk_sel`, `tgt_en` and `wr_inhibit` are all 0 (floating bus).
- R6: When several blocks share a page, only the lowest-numbered block is selected.
- R7: `tgt_rd` is 1 exactly for external read cycles (`bus_wr`=0); it is 0 for external writes and for all internal cycles.
- R8: A write that hits a protected block keeps `blk_sel` on that block and raises `wr_inhibit`. A read of a protected block leaves `wr_inhibit` at 0.
- R9: Such a suppressed write sets the sticky `viol` flag on the strobe edge. A host clear lowers it. If a set and a clear fall on the same edge, the set wins.
- R10: Host port, written when `host_we`=1. `host_reg`=0 loads the index from `host_wdata[7:0]`. `host_reg`=1 writes the block given by index[1:0]: its page comes from `host_wdata[2:0]` and its protect bit from `host_wdata[15]`. `host_reg`=2 writes region index[7:0] as external when `host_wdata[0]`=1. `host_reg`=3 clears `viol`.
- R11: A table write on the same edge as a strobe affects only later cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host register write strobe |
| host_reg | input | 2 | Host register select |
| host_wdata | input | 16 | Host write data |
| bus_strobe | input | 1 | Start of a bus cycle |
| bus_addr | input | 16 | Bus cycle address |
| bus_wr | input | 1 | 1 = write cycle |
| bus_done | input | 1 | End of the current bus cycle |
| blk_sel | output | 4 | One-hot emulation block select |
| tgt_en | output | 1 | Route address/data buffers to the target |
| tgt_rd | output | 1 | Data buffer direction: target toward processor |
| wr_inhibit | output | 1 | Suppress the write into the selected block |
| viol | output | 1 | Sticky write-protect violation flag |

## Verification
Two events can land on one clock edge: a protected-block write that sets the violation flag, and a host clear of that flag. The bench drives both on the same edge and expects the flag to read 1 afterwards. In the same way, it issues a region-table write together with a cycle strobe for that region and expects the old routing for that cycle and the new routing for the next one.

// File: rtl/emu_mem_mapper_pkg.sv
package emu_mem_mapper_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_EXT   = 3'd1,
        ST_SIM   = 3'd2,
        ST_SIM_WP = 3'd3,
        ST_FLOAT = 3'd4
    } map_state_e;

    localparam logic [1:0] HREG_INDEX = 2'd0;
    localparam logic [1:0] HREG_BLOCK = 2'd1;
    localparam logic [1:0] HREG_RGN   = 2'd2;
    localparam logic [1:0] HREG_CLR   = 2'd3;
endpackage

// File: rtl/mm_tables.sv
module mm_tables
    import emu_mem_mapper_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int NBLK   = 4,
    parameter int SIM_SH = 13,
    parameter int RGN_SH = 8,
    parameter int HD_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [1:0]        host_reg,
    input  logic [HD_W-1:0]   host_wdata,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              is_ext,
    output logic [NBLK-1:0]   hit_vec,
    output logic              hit_wp,
    output logic              host_clr
);
    localparam int PAGE_W = ADDR_W - SIM_SH;
    localparam int RGN_W  = ADDR_W - RGN_SH;
    localparam int NRGN   = 1 << RGN_W;
    localparam int BSEL_W = $clog2(NBLK);

    logic [RGN_W-1:0]  idx_q;
    logic [PAGE_W-1:0] base_q [NBLK];
    logic [NBLK-1:0]   wp_q;
    logic [NRGN-1:0]   ext_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            wp_q  <= '0;
            ext_q <= '0;
            for (int i = 0; i < NBLK; i++) base_q[i] <= PAGE_W'(i);
        end else if (host_we) begin
            unique case (host_reg)
                HREG_INDEX: idx_q <= host_wdata[RGN_W-1:0];
                HREG_BLOCK: begin
                    base_q[idx_q[BSEL_W-1:0]] <= host_wdata[PAGE_W-1:0];
                    wp_q[idx_q[BSEL_W-1:0]]   <= host_wdata[HD_W-1];
                end
                HREG_RGN:   ext_q[idx_q] <= host_wdata[0];
                default: ;
            endcase
        end
    end

    assign host_clr = host_we && (host_reg == HREG_CLR);
    assign is_ext   = ext_q[lk_addr[ADDR_W-1:RGN_SH]];

    always_comb begin
        logic found;
        found   = 1'b0;
        hit_vec = '0;
        hit_wp  = 1'b0;
        for (int i = 0; i < NBLK; i++) begin
            if (!found && base_q[i] == lk_addr[ADDR_W-1:SIM_SH]) begin
                found      = 1'b1;
                hit_vec[i] = 1'b1;
                hit_wp     = wp_q[i];
            end
        end
    end

    // R6
    prio_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    // R10
    rgn_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && host_reg == HREG_RGN) |=> ext_q[$past(idx_q)] == $past(host_wdata[0]));
endmodule

// File: rtl/mm_fsm.sv
module mm_fsm
    import emu_mem_mapper_pkg::*;
#(
    parameter int NBLK = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_strobe,
    input  logic            bus_wr,
    input  logic            bus_done,
    input  logic            is_ext,
    input  logic [NBLK-1:0] hit_vec,
    input  logic            hit_wp,
    input  logic            host_clr,
    output logic [NBLK-1:0] blk_sel,
    output logic            tgt_en,
    output logic            tgt_rd,
    output logic            wr_inhibit,
    output logic            viol
);
    map_state_e      state, nxt;
    logic [NBLK-1:0] sel_q;
    logic            wr_q;
    logic            start;

    assign start = (state == ST_IDLE) && bus_strobe;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (bus_strobe) begin
                if (is_ext)                nxt = ST_EXT;
                else if (|hit_vec)         nxt = (bus_wr && hit_wp) ? ST_SIM_WP : ST_SIM;
                else                       nxt = ST_FLOAT;
            end
            ST_EXT, ST_SIM, ST_SIM_WP, ST_FLOAT: if (bus_done) nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            sel_q <= '0;
            wr_q  <= 1'b0;
            viol  <= 1'b0;
        end else begin
            state <= nxt;
            if (start) begin
                sel_q <= hit_vec;
                wr_q  <= bus_wr;
            end
            if (start && nxt == ST_SIM_WP) viol <= 1'b1;
            else if (host_clr)             viol <= 1'b0;
        end
    end

    always_comb begin
        blk_sel    = '0;
        tgt_en     = 1'b0;
        tgt_rd     = 1'b0;
        wr_inhibit = 1'b0;
        unique case (state)
            ST_IDLE, ST_FLOAT: ;
            ST_EXT: begin
                tgt_en = 1'b1;
                tgt_rd = !wr_q;
            end
            ST_SIM:    blk_sel = sel_q;
            ST_SIM_WP: begin
                blk_sel    = sel_q;
                wr_inhibit = 1'b1;
            end
            default: ;
        endcase
    end

    // R4
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(blk_sel));

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && !bus_done) |=> $stable(blk_sel) && $stable(tgt_en));

    // R3
    ext_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && is_ext) |=> tgt_en && blk_sel == '0);

    // R8
    inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_inhibit |-> (wr_q && |blk_sel && !tgt_en));

    // R9
    viol_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(viol) |-> wr_inhibit);
endmodule

// File: rtl/emu_mem_mapper.sv
module emu_mem_mapper
    import emu_mem_mapper_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int NBLK   = 4,
    parameter int SIM_SH = 13,
    parameter int RGN_SH = 8,
    parameter int HD_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [1:0]        host_reg,
    input  logic [HD_W-1:0]   host_wdata,
    input  logic              bus_strobe,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_done,
    output logic [NBLK-1:0]   blk_sel,
    output logic              tgt_en,
    output logic              tgt_rd,
    output logic              wr_inhibit,
    output logic              viol
);
    logic            is_ext;
    logic [NBLK-1:0] hit_vec;
    logic            hit_wp;
    logic            host_clr;

    mm_tables #(
        .ADDR_W(ADDR_W), .NBLK(NBLK), .SIM_SH(SIM_SH), .RGN_SH(RGN_SH), .HD_W(HD_W)
    ) u_tables (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_reg(host_reg),
        .host_wdata(host_wdata), .lk_addr(bus_addr), .is_ext(is_ext),
        .hit_vec(hit_vec), .hit_wp(hit_wp), .host_clr(host_clr)
    );

    mm_fsm #(.NBLK(NBLK)) u_fsm (
        .clk(clk), .rst_n(rst_n), .bus_strobe(bus_strobe), .bus_wr(bus_wr),
        .bus_done(bus_done), .is_ext(is_ext), .hit_vec(hit_vec), .hit_wp(hit_wp),
        .host_clr(host_clr), .blk_sel(blk_sel), .tgt_en(tgt_en), .tgt_rd(tgt_rd),
        .wr_inhibit(wr_inhibit), .viol(viol)
    );

    // R7
    tgt_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_rd |-> tgt_en);
endmodule

// File: tb/emu_mem_mapper_tb.sv
module emu_mem_mapper_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [1:0]  host_reg = 2'd0;
    logic [15:0] host_wdata = '0;
    logic        bus_strobe = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_done = 1'b0;
    logic [3:0]  blk_sel;
    logic        tgt_en, tgt_rd, wr_inhibit, viol;

    int checks = 0;
    int fails  = 0;

    logic [2:0] m_base [4];
    logic [3:0] m_wp;
    logic [255:0] m_ext;
    logic [7:0] m_idx;
    logic       m_viol;

    always #2 clk = ~clk;

    emu_mem_mapper u_dut (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_reg(host_reg),
        .host_wdata(host_wdata), .bus_strobe(bus_strobe), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_done(bus_done), .blk_sel(blk_sel), .tgt_en(tgt_en),
        .tgt_rd(tgt_rd), .wr_inhibit(wr_inhibit), .viol(viol)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_sel(input logic [15:0] a);
        if (m_ext[a[15:8]]) return 4'b0;
        for (int i = 0; i < 4; i++) if (m_base[i] == a[15:13]) return 4'b1 << i;
        return 4'b0;
    endfunction

    function automatic logic exp_wp(input logic [3:0] s);
        for (int i = 0; i < 4; i++) if (s[i]) return m_wp[i];
        return 1'b0;
    endfunction

    task automatic model_host(input logic [1:0] r, input logic [15:0] d);
        case (r)
            2'd0: m_idx = d[7:0];
            2'd1: begin m_base[m_idx[1:0]] = d[2:0]; m_wp[m_idx[1:0]] = d[15]; end
            2'd2: m_ext[m_idx] = d[0];
            default: m_viol = 1'b0;
        endcase
    endtask

    task automatic host(input logic [1:0] r, input logic [15:0] d);
        @(negedge clk);
        host_we = 1'b1; host_reg = r; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
        model_host(r, d);
    endtask

    task automatic check_route(input logic [15:0] a, input logic w, input string tag);
        logic [3:0] es;
        logic ex, inh;
        ex  = m_ext[a[15:8]];
        es  = exp_sel(a);
        inh = !ex && w && exp_wp(es);
        chk(blk_sel == es, {tag, " R4 blk_sel"}, 32'(blk_sel), 32'(es));
        chk(tgt_en == ex, {tag, " R3 tgt_en"}, 32'(tgt_en), 32'(ex));
        chk(tgt_rd == (ex && !w), {tag, " R7 tgt_rd"}, 32'(tgt_rd), 32'(ex && !w));
        chk(wr_inhibit == inh, {tag, " R8 wr_inhibit"}, 32'(wr_inhibit), 32'(inh));
        if (inh) m_viol = 1'b1;
        chk(viol == m_viol, {tag, " R9 viol"}, 32'(viol), 32'(m_viol));
    endtask

    task automatic finish_cycle(input int wait_n);
        repeat (wait_n) begin
            @(negedge clk);
        end
        bus_done = 1'b1;
        @(negedge clk);
        bus_done = 1'b0;
        chk(blk_sel == 0 && !tgt_en && !tgt_rd && !wr_inhibit, "R2 idle after done",
            {28'(0), tgt_en, tgt_rd, wr_inhibit, |blk_sel}, 32'(0));
    endtask

    task automatic access(input logic [15:0] a, input logic w, input string tag);
        logic [3:0] s0;
        @(negedge clk);
        bus_strobe = 1'b1; bus_addr = a; bus_wr = w;
        @(negedge clk);
        bus_strobe = 1'b0;
        check_route(a, w, tag);
        s0 = blk_sel;
        @(negedge clk);
        chk(blk_sel == s0, "R2 held", 32'(blk_sel), 32'(s0));
        finish_cycle(0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED));
        for (int i = 0; i < 4; i++) m_base[i] = 3'(i);
        m_wp = '0; m_ext = '0; m_idx = '0; m_viol = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(blk_sel == 0 && !tgt_en && !tgt_rd && !wr_inhibit && !viol, "R1 reset outputs",
            {27'(0), viol, tgt_en, tgt_rd, wr_inhibit, |blk_sel}, 32'(0));
        access(16'h0000, 1'b0, "R1 default blk0");
        access(16'h7FFE, 1'b1, "R1 default blk3");
        access(16'h8000, 1'b0, "R5 float");
        access(16'hE123, 1'b1, "R5 float write");
        // R3 external override, R7 direction
        host(2'd0, 16'h0000);
        host(2'd2, 16'h0001);
        access(16'h0010, 1'b0, "R3 ext read");
        access(16'h00FF, 1'b1, "R3 ext write");
        access(16'h0100, 1'b0, "R3 neighbour internal");
        host(2'd2, 16'h0000);
        // R6 duplicate page
        host(2'd0, 16'h0002);
        host(2'd1, 16'h0000);
        access(16'h0400, 1'b0, "R6 lowest wins");
        host(2'd0, 16'h0000);
        host(2'd1, 16'h0007);
        access(16'h0400, 1'b0, "R6 block2 now");
        access(16'hFFFF, 1'b0, "R4 relocated page7");
        // R8/R9 protection
        host(2'd0, 16'h0001);
        host(2'd1, 16'h8001);
        access(16'h2000, 1'b0, "R8 wp read");
        access(16'h2002, 1'b1, "R8 wp write");
        host(2'd3, 16'h0000);
        @(negedge clk);
        chk(viol == 1'b0, "R9 cleared", 32'(viol), 32'(0));
        // R9 set and clear on the same edge
        @(negedge clk);
        bus_strobe = 1'b1; bus_addr = 16'h2004; bus_wr = 1'b1;
        host_we = 1'b1; host_reg = 2'd3;
        @(negedge clk);
        bus_strobe = 1'b0; host_we = 1'b0;
        m_viol = 1'b0;
        check_route(16'h2004, 1'b1, "R9 set wins");
        finish_cycle(1);
        host(2'd3, 16'h0000);
        // R11 table write on the strobe edge
        host(2'd0, 16'h0030);
        @(negedge clk);
        bus_strobe = 1'b1; bus_addr = 16'h3040; bus_wr = 1'b0;
        host_we = 1'b1; host_reg = 2'd2; host_wdata = 16'h0001;
        @(negedge clk);
        bus_strobe = 1'b0; host_we = 1'b0;
        check_route(16'h3040, 1'b0, "R11 old table");
        model_host(2'd2, 16'h0001);
        finish_cycle(0);
        access(16'h3040, 1'b0, "R11 new table");
        // random phase
        for (int n = 0; n < 300; n++) begin
            int k;
            k = int'($urandom_range(0, 9));
            if (k < 2) begin
                host(2'd0, 16'($urandom_range(0, 255)));
                host(2'd2, 16'($urandom_range(0, 3) == 0));
            end else if (k < 3) begin
                host(2'd0, 16'($urandom_range(0, 3)));
                host(2'd1, {1'($urandom_range(0, 1)), 12'd0, 3'($urandom_range(0, 7))});
            end else if (k < 4) begin
                host(2'd3, 16'h0000);
            end else begin
                access(16'($urandom), 1'($urandom_range(0, 1)), "R10 random");
            end
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule